// File: doc/BRIEF.md
# PCI Target Data-Phase Sequencer

This block is the slave-side bus sequencer of a 32-bit PCI target. It watches the cycle frame, initiator ready, the configuration chip-select and the command/byte-enable lines. It decodes memory and configuration accesses that belong to it and claims them by pulling the device-select line low with medium decode timing. It then paces each data phase with target ready, and it ends a burst early with stop when the next word would fall outside its decoded window.

On the inside it offers a small register port: an address, a configuration-space flag, a write strobe that fires on each completed write phase, a read strobe that fires when read data is fetched, byte enables, write data, read data and a ready input from the register file. Reads wait a fixed, parameter-set number of clocks before each data phase. All bus outputs come from registers. The three target control lines have one shared output enable. The read data bus has its own enable.

Top module: `pci_tgt_seq`

## Requirements
- R1: While reset is low and just after it, `devsel_n`, `trdy_n` and `stop_n` are high, and `ctl_oe`, `ad_oe`, `reg_wr` and `reg_rd` are low.
- R2: A memory access is claimed when its command is 0110, 0111, 1100, 1110 or 1111 and its address lies in the window of `WIN_BYTES` bytes at `BAR_BASE`. Any other command, and any address outside the window, never drives `ctl_oe` or `devsel_n`.
- R3: A configuration read (1010) or write (1011) is claimed only when `idsel` is high and address bits [1:0] are 00 in the address clock. Its window is 256 bytes, and `reg_cfg` is high throughout the access.
- R4: Call the clock edge that samples `frame_n` low from idle the address edge. `ctl_oe` rises after that edge with all three control lines high. `devsel_n` falls one edge later and stays low until the transaction ends. `trdy_n` and `stop_n` go low only while `devsel_n` is low.
- R5: A data phase completes only on an edge where `irdy_n` and `trdy_n` are both low. A write raises `reg_wr` in exactly that cycle, with `reg_wdata` = `ad_in` and `reg_be` = the inverse of `cbe_n`. A read presents on `ad_out` the `reg_rdata` word for the phase's address.
- R6: The phase address starts at the latched address and rises by 4 after each completed phase. It is held while a phase is pending. On a write it is shown on `reg_addr` when `reg_wr` fires.
- R7: A write's first `trdy_n` low follows the address edge by two edges. A read's first `trdy_n` low follows it by 2 + `RD_WAIT` edges. Between read phases `trdy_n` stays high for exactly `RD_WAIT` clocks (with `reg_ready` high).
- R8: Once low, `trdy_n` stays low until the phase completes. `trdy_n` is never asserted on an edge where `reg_ready` was low.
- R9: After the final phase completes, the next clock shows all three control lines high with `ctl_oe` still high, and `ctl_oe` falls one clock later. `ad_oe` is off after the last read phase.
- R10: When the phase being offered is the last word of the window and `frame_n` is low, `stop_n` falls together with `trdy_n`. After that phase completes, `trdy_n` is high and `stop_n` stays low until `frame_n` is sampled high. No further phase completes. With `frame_n` already high, no stop is given.
- R11: After a transaction that is not claimed, the block drives nothing until both `frame_n` and `irdy_n` are high. It then claims the next matching access normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle frame from initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select |
| cbe_n | input | 4 | Command in address clock, byte enables (active low) in data clocks |
| ad_in | input | 32 | Address/data bus as received |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Output enable for the three target control lines |
| reg_addr | output | 32 | Register address of the current access |
| reg_cfg | output | 1 | Access is in configuration space |
| reg_wr | output | 1 | Write strobe, one per completed write phase |
| reg_rd | output | 1 | Read fetch strobe, data taken at the next edge |
| reg_be | output | 4 | Byte enables, active high |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data from register file |
| reg_ready | input | 1 | Register file can accept or supply a word |

## Verification
The properties cover the cycle-level rules on every edge: medium device-select timing, target ready and stop only under device select, target ready held until the handshake, the address that is held or stepped by four, the write strobe only on a handshake, stop held until the frame ends, and quiet lines before the enable drops. The bench scenarios cover what needs knowledge of the whole transaction. These are the decode decisions for each command, address and chip-select combination, the data that flows through in both directions, the read wait count, the number of phases before a disconnect at the window edge, and recovery after an access that is not claimed.

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq #(
  parameter logic [31:0] BAR_BASE  = 32'h1000_0000,
  parameter int          WIN_BYTES = 64,
  parameter int          RD_WAIT   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe,
  output logic [31:0] reg_addr,
  output logic        reg_cfg,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic [3:0]  reg_be,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata,
  input  logic        reg_ready
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int CFG_AW = 8;
  localparam int WCW    = $clog2(RD_WAIT + 2);
  localparam logic [WCW-1:0] WAIT_V = WCW'(RD_WAIT);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_DATA, S_STOPW, S_TURN, S_SKIP} st_t;

  st_t             st;
  logic [31:0]     addr_q;
  logic            cfg_q, wr_q;
  logic [WCW-1:0]  wcnt;
  logic            devsel_q, trdy_q, stop_q, oe_q, adoe_q;
  logic [31:0]     adout_q;

  logic mem_cmd, cfg_cmd, mem_hit, cfg_hit;
  logic hs, open_phase, can_go, load, last_word;
  logic [31:0]    addr_nxt;
  logic [WCW-1:0] cnt_now;

  assign mem_cmd = cbe_n inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
  assign cfg_cmd = cbe_n inside {4'b1010, 4'b1011};
  assign mem_hit = mem_cmd && (ad_in[31:WIN_AW] == BAR_BASE[31:WIN_AW]);
  assign cfg_hit = cfg_cmd && idsel && (ad_in[1:0] == 2'b00);

  assign hs         = (st == S_DATA) && !trdy_q && !irdy_n;
  assign addr_nxt   = hs ? addr_q + 32'd4 : addr_q;
  assign cnt_now    = hs ? '0 : wcnt;
  assign can_go     = reg_ready && (wr_q || cnt_now >= WAIT_V);
  assign open_phase = (st == S_DATA) && (trdy_q || hs) && !(hs && frame_n) && !(hs && !stop_q);
  assign load       = open_phase && can_go;
  assign last_word  = cfg_q ? &addr_nxt[CFG_AW-1:2] : &addr_nxt[WIN_AW-1:2];

  assign ad_out    = adout_q;
  assign ad_oe     = adoe_q;
  assign devsel_n  = devsel_q;
  assign trdy_n    = trdy_q;
  assign stop_n    = stop_q;
  assign ctl_oe    = oe_q;
  assign reg_addr  = wr_q ? addr_q : addr_nxt;
  assign reg_cfg   = cfg_q;
  assign reg_wr    = hs && wr_q;
  assign reg_rd    = load && !wr_q;
  assign reg_be    = ~cbe_n;
  assign reg_wdata = ad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cfg_q    <= 1'b0;
      wr_q     <= 1'b0;
      wcnt     <= '0;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      stop_q   <= 1'b1;
      oe_q     <= 1'b0;
      adoe_q   <= 1'b0;
      adout_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!frame_n) begin
            addr_q <= ad_in;
            cfg_q  <= cfg_hit;
            wr_q   <= cbe_n[0];
            if (mem_hit || cfg_hit) begin
              st   <= S_DEC;
              oe_q <= 1'b1;
            end else begin
              st <= S_SKIP;
            end
          end
        end
        S_DEC: begin
          st       <= S_DATA;
          devsel_q <= 1'b0;
          adoe_q   <= !wr_q;
          wcnt     <= '0;
        end
        S_DATA: begin
          addr_q <= addr_nxt;
          if (hs && frame_n) begin
            st       <= S_TURN;
            devsel_q <= 1'b1;
            trdy_q   <= 1'b1;
            stop_q   <= 1'b1;
            adoe_q   <= 1'b0;
          end else if (hs && !stop_q) begin
            st     <= S_STOPW;
            trdy_q <= 1'b1;
            adoe_q <= 1'b0;
          end else if (open_phase) begin
            if (can_go) begin
              trdy_q  <= 1'b0;
              stop_q  <= !(last_word && !frame_n);
              adout_q <= reg_rdata;
              wcnt    <= '0;
            end else begin
              trdy_q <= 1'b1;
              wcnt   <= (cnt_now == WAIT_V) ? cnt_now : cnt_now + 1'b1;
            end
          end
        end
        S_STOPW: begin
          if (frame_n) begin
            st       <= S_TURN;
            devsel_q <= 1'b1;
            stop_q   <= 1'b1;
          end
        end
        S_TURN: begin
          st   <= S_IDLE;
          oe_q <= 1'b0;
        end
        S_SKIP: begin
          if (frame_n && irdy_n) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_seq_chk.sv
module pci_tgt_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n,
  input logic        ctl_oe,
  input logic        reg_wr,
  input logic [31:0] addr_q
);
  AST_DEVSEL_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(ctl_oe) && !$past(ctl_oe, 2) && !$past(frame_n, 2))); // R4
  AST_TRDY_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (!devsel_n && ctl_oe)); // R4
  AST_WR_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (!trdy_n && !irdy_n)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && (trdy_n || irdy_n)) |=> $stable(addr_q)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !trdy_n && !irdy_n) |=> (addr_q == $past(addr_q) + 32'd4)); // R6
  AST_TRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> !trdy_n); // R8
  AST_QUIET_BEFORE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n)); // R9
  AST_STOP_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n); // R10
  AST_STOP_UNTIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n); // R10
endmodule

bind pci_tgt_seq pci_tgt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
  .reg_wr(reg_wr), .addr_q(addr_q)
);

// File: tb/tb_pci_tgt_seq.sv
module tb_pci_tgt_seq;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int WIN = 64;
  localparam int W   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, reg_ready = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out, reg_addr, reg_wdata, reg_rdata;
  logic ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, reg_cfg, reg_wr, reg_rd;
  logic [3:0] reg_be;

  always #2 clk = ~clk;

  pci_tgt_seq #(.BAR_BASE(BASE), .WIN_BYTES(WIN), .RD_WAIT(W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .reg_addr(reg_addr), .reg_cfg(reg_cfg), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready));

  function automatic logic [31:0] rdm(input logic cfg, input logic [31:0] a);
    return cfg ? (32'hCF00_0000 | a) : (a ^ 32'h5A5A_0000);
  endfunction
  function automatic logic [31:0] wdm(input logic [31:0] a);
    return a ^ 32'hD00D_0000;
  endfunction
  function automatic logic [3:0] bnm(input int i);
    return 4'(i + 1);
  endfunction

  assign reg_rdata = rdm(reg_cfg, reg_addr);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  logic [31:0] q_rd[$];
  logic [31:0] q_wa[$];
  logic [31:0] q_wd[$];
  logic [3:0]  q_wb[$];

  bit mon_hs, mon_stop, mon_frame_n, tr_rd, seen_hs, any_claim;
  bit prev_trdy_n = 1, prev_ready = 1;
  int tr_oe, tr_dev, tr_devoff, tr_oeoff, tr_stop, tr_trdy, tr_trdy_last, tr_lasths;
  int gap_run, gaps_bad, rdy_viol, t_addr, done_g;

  always @(negedge clk) begin
    if (rst_n) begin
      mon_hs = !trdy_n && !irdy_n;
      mon_stop = !stop_n;
      mon_frame_n = frame_n;
      if (ctl_oe || !devsel_n) any_claim = 1;
      if (ctl_oe && tr_oe < 0) tr_oe = cyc;
      if (!devsel_n && tr_dev < 0) tr_dev = cyc;
      if (devsel_n && tr_dev >= 0 && tr_devoff < 0) tr_devoff = cyc;
      if (!ctl_oe && tr_oe >= 0 && tr_oeoff < 0) tr_oeoff = cyc;
      if (!stop_n && tr_stop < 0) tr_stop = cyc;
      if (!trdy_n && prev_trdy_n) begin
        if (tr_trdy < 0) tr_trdy = cyc;
        tr_trdy_last = cyc;
        if (!prev_ready) rdy_viol++;
        if (seen_hs && tr_rd && gap_run != W) gaps_bad++;
      end
      if (!devsel_n && trdy_n && seen_hs) gap_run++;
      if (mon_hs) begin
        tr_lasths = cyc;
        seen_hs = 1;
        gap_run = 0;
        if (tr_rd) begin
          if (q_rd.size() == 0) chk("R5", "unexpected read phase", 1, 0);
          else chk("R5", "read data", ad_out, q_rd.pop_front());
        end
      end
      if (reg_wr) begin
        if (q_wa.size() == 0) chk("R5", "unexpected write strobe", 1, 0);
        else begin
          chk("R6", "write address", reg_addr, q_wa.pop_front());
          chk("R5", "write data", reg_wdata, q_wd.pop_front());
          chk("R5", "byte enables", reg_be, q_wb.pop_front());
        end
      end
      prev_trdy_n = trdy_n;
      prev_ready = reg_ready;
    end
  end

  task automatic xfer(input logic [3:0] cmd, input logic [31:0] a, input logic sel,
                      input int n, input int n_exp, input int igap);
    bit cfg;
    int hold, waitc;
    cfg = (cmd == 4'b1010) || (cmd == 4'b1011);
    tr_rd = !cmd[0];
    tr_oe = -1; tr_dev = -1; tr_devoff = -1; tr_oeoff = -1; tr_stop = -1;
    tr_trdy = -1; tr_trdy_last = -1; tr_lasths = -1;
    gap_run = 0; gaps_bad = 0; rdy_viol = 0; seen_hs = 0; any_claim = 0; done_g = 0;
    for (int i = 0; i < n_exp; i++) begin
      if (tr_rd) q_rd.push_back(rdm(cfg, a + 32'(4 * i)));
      else begin
        q_wa.push_back(a + 32'(4 * i));
        q_wd.push_back(wdm(a + 32'(4 * i)));
        q_wb.push_back(~bnm(i));
      end
    end
    @(posedge clk); #1;
    frame_n = 0; ad_in = a; cbe_n = cmd; idsel = sel;
    @(posedge clk); #1;
    t_addr = cyc;
    idsel = 0; cbe_n = bnm(0); ad_in = tr_rd ? 32'h0 : wdm(a);
    hold = igap;
    irdy_n = (igap > 0);
    if (igap == 0 && n == 1) frame_n = 1;
    waitc = 0;
    forever begin
      @(posedge clk); #1;
      waitc++;
      if (hold > 0) begin
        hold--;
        if (hold == 0) begin irdy_n = 0; if (n == 1) frame_n = 1; end
      end else if (mon_hs) begin
        done_g++;
        if (mon_frame_n) begin frame_n = 1; irdy_n = 1; break; end
        cbe_n = bnm(done_g);
        if (!tr_rd) ad_in = wdm(a + 32'(4 * done_g));
        if (mon_stop || done_g == n - 1) frame_n = 1;
      end else if (mon_stop) begin
        if (mon_frame_n) begin irdy_n = 1; break; end
        frame_n = 1;
      end else if (waitc > 6 && tr_dev < 0) begin
        if (frame_n) begin irdy_n = 1; break; end
        frame_n = 1;
      end
    end
    cbe_n = 4'hF; ad_in = '0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic queues_empty(input string req);
    chk(req, "scoreboard left over", q_rd.size() + q_wa.size(), 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "devsel_n in reset", devsel_n, 1);
    chk("R1", "trdy_n/stop_n in reset", {trdy_n, stop_n}, 2'b11);
    chk("R1", "enables and strobes in reset", {ctl_oe, ad_oe, reg_wr, reg_rd}, 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "outputs after reset", {devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 5'b11100);

    // R4 R5 R7 R9: read burst of four at the window base
    xfer(4'b0110, BASE, 0, 4, 4, 0);
    chk("R5", "read phases completed", done_g, 4);
    queues_empty("R5");
    chk("R4", "ctl_oe rises after address edge", tr_oe, t_addr);
    chk("R4", "devsel_n falls one edge later", tr_dev, t_addr + 1);
    chk("R7", "first read trdy_n", tr_trdy, t_addr + 2 + W);
    chk("R7", "read gaps equal RD_WAIT", gaps_bad, 0);
    chk("R9", "devsel_n high after last phase", tr_devoff, tr_lasths + 1);
    chk("R9", "ctl_oe off one clock later", tr_oeoff, tr_lasths + 2);
    chk("R9", "ad_oe off", ad_oe, 0);
    chk("R10", "no stop inside window", tr_stop, -1);

    // R5 R6 R8: write burst with initiator wait states
    xfer(4'b0111, BASE + 8, 0, 3, 3, 2);
    chk("R5", "write phases completed", done_g, 3);
    queues_empty("R6");
    chk("R7", "first write trdy_n", tr_trdy, t_addr + 2);

    // R8: register file not ready
    reg_ready = 0;
    fork
      begin repeat (5) @(posedge clk); #1 reg_ready = 1; end
    join_none
    xfer(4'b0111, BASE + 20, 0, 2, 2, 0);
    chk("R8", "trdy_n while reg_ready low", rdy_viol, 0);
    chk("R8", "trdy_n delayed by reg_ready", tr_trdy > t_addr + 2, 1);
    queues_empty("R8");

    // R10: read burst running into the window end
    xfer(4'b1100, BASE + WIN - 12, 0, 6, 3, 0);
    chk("R10", "phases before disconnect", done_g, 3);
    chk("R10", "stop_n with last trdy_n", tr_stop, tr_trdy_last);
    queues_empty("R10");
    chk("R9", "released after disconnect", {devsel_n, stop_n, ctl_oe}, 3'b110);

    // R10: single write at last word, frame already high
    xfer(4'b0111, BASE + WIN - 4, 0, 1, 1, 0);
    chk("R10", "no stop on final phase", tr_stop, -1);
    queues_empty("R10");

    // R2: miss and foreign command
    xfer(4'b0110, BASE + WIN, 0, 1, 0, 0);
    chk("R2", "address outside window", any_claim, 0);
    xfer(4'b0010, BASE, 0, 1, 0, 0);
    chk("R2", "unsupported command", any_claim, 0);
    xfer(4'b1110, BASE + 16, 0, 2, 2, 0);
    chk("R2", "read-line command claimed", done_g, 2);
    queues_empty("R2");

    // R11: unclaimed write burst, then a claimed one
    xfer(4'b0111, BASE - 64, 0, 3, 0, 0);
    chk("R11", "unclaimed burst", any_claim, 0);
    xfer(4'b0111, BASE + 4, 0, 1, 1, 0);
    chk("R11", "claim after unclaimed", done_g, 1);
    queues_empty("R11");

    // R3: configuration space
    xfer(4'b1010, 32'h0000_0010, 1, 2, 2, 0);
    chk("R3", "config read with idsel", done_g, 2);
    queues_empty("R3");
    xfer(4'b1010, 32'h0000_0010, 0, 1, 0, 0);
    chk("R3", "config without idsel", any_claim, 0);
    xfer(4'b1011, 32'h0000_0011, 1, 1, 0, 0);
    chk("R3", "config with ad[1:0]=01", any_claim, 0);
    xfer(4'b1011, 32'h0000_00F8, 1, 4, 2, 0);
    chk("R3", "config write burst at space end", done_g, 2);
    chk("R10", "config disconnect", tr_stop >= 0, 1);
    queues_empty("R3");

    summary();
  end
endmodule